// File: doc/BRIEF.md
# Serial Audio Bit and Frame Clock Divider

This block turns a master-clock enable strobe into the two timing clocks of a serial audio link. A bit clock is made by dividing the master-clock ticks by 2 or by 4. A left/right frame clock is then made by dividing the bit clock by 32, 64 or 128. Both are produced as levels, together with one-cycle strobes that mark each transition. Everything runs in the system clock domain. The master clock exists only as the `mclk_tick` enable that comes from an upstream fractional generator.

The configuration arrives as a 32-bit control word, and its fields sit at fixed positions. One enable bit starts or stops both clocks together. A polarity bit chooses which bit-clock edge moves the frame clock. An override bit chooses where the divide and polarity settings come from: either the control-word fields, or a second set of settings supplied by the attached audio block. The frame clock has a 50 % duty cycle. Each frame begins low for the first half of its bit clocks and is high for the second half.

Top module: `serial_clk_div`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is low after that edge.
- R2: The bit-clock select (control bit 16, or `aud_bdiv_sel` when not overridden) gives a divide of 2 for value 0 and a divide of 4 for value 1. After enable the bit clock starts low and toggles once for every 1 (divide 2) or every 2 (divide 4) master ticks.
- R3: Frame select values 0, 1 and 2 (control bits 18:17, or `aud_fdiv_sel`) give a frame of 32, 64 and 128 bit clocks. The frame clock is low for the first half of the frame and high for the second half.
- R4: Frame select value 3 is illegal. The frame clock is held low and its count is cleared, while the bit clock keeps running.
- R5: Control bit 31 enables both clocks. When it is 0, all outputs are low one cycle later and both counters are cleared. After re-enabling, the first frame-clock rise comes after exactly half a frame of selected bit-clock edges.
- R6: With polarity 1 (control bit 19, or `aud_fall_pol`) the frame clock changes only in the cycle in which the bit clock falls. With polarity 0 it changes only in the cycle in which the bit clock rises.
- R7: With control bit 29 set, the divide and polarity settings come from the control word. With it clear, they come from the `aud_*` inputs. The enable is always taken from bit 31.
- R8: `bclk_rise_o` and `bclk_fall_o` are high for exactly the cycle in which `bclk_o` has just risen or fallen. `fclk_edge_o` is high for exactly the cycle in which `fclk_o` has just toggled by counting. A forced stop gives no strobe.
- R9: The bit clock changes only in the cycle after a clock edge at which `mclk_tick` was high, or as a result of disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_tick | input | 1 | Master clock enable, one strobe per master period |
| ctl_word | input | 32 | Control word: [31] enable, [29] override, [19] polarity, [18:17] frame select, [16] bit select |
| aud_bdiv_sel | input | 1 | Bit-clock select from the audio block (used when bit 29 is clear) |
| aud_fdiv_sel | input | 2 | Frame select from the audio block |
| aud_fall_pol | input | 1 | Polarity from the audio block |
| bclk_o | output | 1 | Bit clock level |
| bclk_rise_o | output | 1 | Bit clock rose this cycle |
| bclk_fall_o | output | 1 | Bit clock fell this cycle |
| fclk_o | output | 1 | Frame clock level |
| fclk_edge_o | output | 1 | Frame clock toggled this cycle |

## Verification
A bit-clock transition and a frame-clock transition land in the same cycle on every frame boundary. This is the point where a wrong edge choice or an off-by-one delay would show. The bench sets up both polarities at full and at sparse master-tick rates, and checks each `fclk_edge_o` against the bit-clock strobe of that same cycle. A behavioural model, compared on every clock, also judges the cases where a disable or an illegal frame select arrives on the cycle a transition was due.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
   // control-word field positions (decoded by neighbouring logic)
   localparam int unsigned CW_BSEL   = 16;
   localparam int unsigned CW_FSEL   = 17;
   localparam int unsigned CW_POL    = 19;
   localparam int unsigned CW_OVR    = 29;
   localparam int unsigned CW_EN     = 31;
   localparam int unsigned FSEL_W    = 2;
   localparam int unsigned FSEL_LEGAL = 3;

   typedef struct packed {
      logic              en;
      logic              bsel;
      logic [FSEL_W-1:0] fsel;
      logic              fall_pol;
      logic              stop;
   } sclk_cfg_t;
endpackage

// File: rtl/sclk_cfg_sel.sv
module sclk_cfg_sel
   import sclk_div_pkg::*;
(
   input  logic [31:0]       ctl_word,
   input  logic              aud_bdiv_sel,
   input  logic [FSEL_W-1:0] aud_fdiv_sel,
   input  logic              aud_fall_pol,
   output sclk_cfg_t         cfg
);
   logic              ovr;
   logic [FSEL_W-1:0] fsel_w;

   assign ovr    = ctl_word[CW_OVR];
   assign fsel_w = ovr ? ctl_word[CW_FSEL +: FSEL_W] : aud_fdiv_sel;

   always_comb begin
      cfg.en       = ctl_word[CW_EN];
      cfg.bsel     = ovr ? ctl_word[CW_BSEL] : aud_bdiv_sel;
      cfg.fsel     = fsel_w;
      cfg.fall_pol = ovr ? ctl_word[CW_POL] : aud_fall_pol;
      cfg.stop     = (32'(fsel_w) >= FSEL_LEGAL);
   end
endmodule

// File: rtl/sclk_bit_div.sv
module sclk_bit_div #(
   parameter int unsigned BSEL_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic [BSEL_W-1:0] bsel,
   output logic              rise_nxt,
   output logic              fall_nxt,
   output logic              bclk,
   output logic              rise,
   output logic              fall
);
   localparam int unsigned MAX_HALF = 1 << ((1 << BSEL_W) - 1);
   localparam int unsigned CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

   initial begin : p_param_chk
      assert (BSEL_W >= 1 && BSEL_W <= 3) else $error("BSEL_W out of range");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_m1;
   logic             wrap;

   assign half_m1  = CNT_W'((1 << bsel) - 1);
   assign wrap     = en && tick && (cnt >= half_m1);
   assign rise_nxt = wrap && !bclk;
   assign fall_nxt = wrap && bclk;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt  <= '0;
         bclk <= 1'b0;
         rise <= 1'b0;
         fall <= 1'b0;
      end else begin
         rise <= rise_nxt;
         fall <= fall_nxt;
         if (wrap) begin
            cnt  <= '0;
            bclk <= ~bclk;
         end else if (tick) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R9: the bit clock moves only after a master tick or on disable
   a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      (bclk != $past(bclk)) |-> ($past(tick) || !$past(en)));
   // R8: rise and fall strobes are never high together
   a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise, fall}));
   // R8: a rise strobe means the level went from low to high
   a_r8_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> (bclk && !$past(bclk)));
endmodule

// File: rtl/sclk_frame_div.sv
module sclk_frame_div #(
   parameter int unsigned FRAME_MIN = 32,
   parameter int unsigned FSEL_W    = 2,
   parameter int unsigned N_LEGAL   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stop,
   input  logic              step,
   input  logic [FSEL_W-1:0] fsel,
   output logic              fclk,
   output logic              fedge
);
   localparam int unsigned HALF_MAX = (FRAME_MIN / 2) << (N_LEGAL - 1);
   localparam int unsigned CNT_W    = $clog2(HALF_MAX);

   initial begin : p_param_chk
      assert (FRAME_MIN >= 4 && (FRAME_MIN & (FRAME_MIN - 1)) == 0)
         else $error("FRAME_MIN must be a power of two >= 4");
      assert (N_LEGAL >= 1 && N_LEGAL <= (1 << FSEL_W))
         else $error("N_LEGAL does not fit FSEL_W");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_m1;

   assign half_m1 = CNT_W'(((FRAME_MIN / 2) << fsel) - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || !en || stop) begin
         cnt   <= '0;
         fclk  <= 1'b0;
         fedge <= 1'b0;
      end else begin
         fedge <= 1'b0;
         if (step) begin
            if (cnt >= half_m1) begin
               cnt   <= '0;
               fclk  <= ~fclk;
               fedge <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R4: an illegal select leaves the frame clock low
   a_r4_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !fclk);
   // R3: the frame clock toggles only on a counted bit-clock edge
   a_r3_step_only: assert property (@(posedge clk) disable iff (!rst_n)
      fedge |-> $past(step));
endmodule

// File: rtl/serial_clk_div.sv
module serial_clk_div
   import sclk_div_pkg::*;
#(
   parameter int unsigned FRAME_MIN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mclk_tick,
   input  logic [31:0]       ctl_word,
   input  logic              aud_bdiv_sel,
   input  logic [FSEL_W-1:0] aud_fdiv_sel,
   input  logic              aud_fall_pol,
   output logic              bclk_o,
   output logic              bclk_rise_o,
   output logic              bclk_fall_o,
   output logic              fclk_o,
   output logic              fclk_edge_o
);
   sclk_cfg_t cfg;
   logic      rise_nxt, fall_nxt, step;

   sclk_cfg_sel i_cfg (
      .ctl_word     (ctl_word),
      .aud_bdiv_sel (aud_bdiv_sel),
      .aud_fdiv_sel (aud_fdiv_sel),
      .aud_fall_pol (aud_fall_pol),
      .cfg          (cfg)
   );

   sclk_bit_div #(.BSEL_W(1)) i_bit (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg.en),
      .tick     (mclk_tick),
      .bsel     (cfg.bsel),
      .rise_nxt (rise_nxt),
      .fall_nxt (fall_nxt),
      .bclk     (bclk_o),
      .rise     (bclk_rise_o),
      .fall     (bclk_fall_o)
   );

   assign step = cfg.fall_pol ? fall_nxt : rise_nxt;

   sclk_frame_div #(.FRAME_MIN(FRAME_MIN), .FSEL_W(FSEL_W), .N_LEGAL(FSEL_LEGAL)) i_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg.en),
      .stop  (cfg.stop),
      .step  (step),
      .fsel  (cfg.fsel),
      .fclk  (fclk_o),
      .fedge (fclk_edge_o)
   );

   // R5: disable drives both clocks low on the next cycle
   a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_word[CW_EN] |=> (!bclk_o && !fclk_o));
   // R6: a counted frame toggle sits on the bit-clock edge picked by polarity
   a_r6_edge_pol: assert property (@(posedge clk) disable iff (!rst_n)
      fclk_edge_o |-> ($past(cfg.fall_pol) ? bclk_fall_o : bclk_rise_o));
   // R8: any frame-clock change without a strobe is a forced return to low
   a_r8_fclk_forced: assert property (@(posedge clk) disable iff (!rst_n)
      ((fclk_o != $past(fclk_o)) && !fclk_edge_o) |-> !fclk_o);
endmodule

// File: tb/test_serial_clk_div.sv
module test_serial_clk_div;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mclk_tick = 1'b0;
   logic [31:0] ctl_word = '0;
   logic        aud_bdiv_sel = 1'b0;
   logic [1:0]  aud_fdiv_sel = 2'd0;
   logic        aud_fall_pol = 1'b0;
   logic        bclk_o, bclk_rise_o, bclk_fall_o, fclk_o, fclk_edge_o;

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit cmp_on = 0;
   int tick_mode = 0;

   always #(PERIOD/2) clk = ~clk;

   serial_clk_div i_serial_clk_div (
      .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .ctl_word(ctl_word),
      .aud_bdiv_sel(aud_bdiv_sel), .aud_fdiv_sel(aud_fdiv_sel), .aud_fall_pol(aud_fall_pol),
      .bclk_o(bclk_o), .bclk_rise_o(bclk_rise_o), .bclk_fall_o(bclk_fall_o),
      .fclk_o(fclk_o), .fclk_edge_o(fclk_edge_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // master tick generator: 0 = every cycle, 1 = every third, 2 = random
   int tdiv = 0;
   always @(negedge clk) begin
      #1;
      tdiv = (tdiv + 1) % 3;
      case (tick_mode)
         0: mclk_tick = 1'b1;
         1: mclk_tick = (tdiv == 0);
         default: mclk_tick = ($urandom_range(0, 1) == 1);
      endcase
   end

   // behavioural reference
   int m_mc, m_fc;
   bit m_bclk, m_r, m_f, m_fclk, m_fe;
   always @(posedge clk) begin
      bit ov, bs, pl, en;
      int fs;
      ov = ctl_word[29];
      en = ctl_word[31];
      bs = ov ? ctl_word[16] : aud_bdiv_sel;
      fs = ov ? int'(ctl_word[18:17]) : int'(aud_fdiv_sel);
      pl = ov ? ctl_word[19] : aud_fall_pol;
      if (!rst_n || !en) begin
         m_mc = 0; m_fc = 0; m_bclk = 0; m_fclk = 0; m_r = 0; m_f = 0; m_fe = 0;
      end else begin
         m_r = 0; m_f = 0; m_fe = 0;
         if (mclk_tick) begin
            m_mc++;
            if (m_mc >= (bs ? 2 : 1)) begin
               m_mc = 0;
               m_bclk = !m_bclk;
               if (m_bclk) m_r = 1; else m_f = 1;
            end
         end
         if (fs == 3) begin
            m_fc = 0; m_fclk = 0;
         end else if (pl ? m_f : m_r) begin
            m_fc++;
            if (m_fc >= (16 << fs)) begin
               m_fc = 0; m_fclk = !m_fclk; m_fe = 1;
            end
         end
      end
   end

   // per-cycle comparison and trackers
   int rises_in_frame = 0, last_ratio = 0, frames = 0;
   int cyc_since_rise = 0, last_bper = 0, bclk_rises = 0;
   bit fclk_seen_high = 0;
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R2/R9 bclk", bclk_o, m_bclk);
         chk("R8 bclk_rise", bclk_rise_o, m_r);
         chk("R8 bclk_fall", bclk_fall_o, m_f);
         chk("R3 fclk", fclk_o, m_fclk);
         chk("R8 fclk_edge", fclk_edge_o, m_fe);
         if (fclk_edge_o)
            chk("R6 edge polarity", ctl_word[29] ? (ctl_word[19] ? bclk_fall_o : bclk_rise_o)
                                                  : (aud_fall_pol ? bclk_fall_o : bclk_rise_o), 1);
      end
      cyc_since_rise++;
      if (bclk_rise_o) begin
         rises_in_frame++; bclk_rises++;
         last_bper = cyc_since_rise; cyc_since_rise = 0;
      end
      if (fclk_edge_o && fclk_o) begin
         last_ratio = rises_in_frame; rises_in_frame = 0; frames++;
      end
      if (fclk_o) fclk_seen_high = 1;
   end

   task automatic drive(input bit en, input bit ov, input bit pol, input int fs, input bit bs);
      @(negedge clk); #1;
      ctl_word = '0;
      ctl_word[31] = en; ctl_word[29] = ov; ctl_word[19] = pol;
      ctl_word[18:17] = 2'(fs); ctl_word[16] = bs;
      rises_in_frame = 0; frames = 0; bclk_rises = 0; fclk_seen_high = 0;
   endtask

   task automatic wait_frames(input int n);
      int guard = 0;
      while (frames < n && guard < 20000) begin
         @(negedge clk); guard++;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 bclk", bclk_o, 0); chk("R1 fclk", fclk_o, 0);
      chk("R1 strobes", {bclk_rise_o, bclk_fall_o, fclk_edge_o}, 0);
      @(negedge clk); #1; rst_n = 1'b1; cmp_on = 1;

      // R2 R3 divide 2, frame 32, rising edge
      tick_mode = 0;
      drive(1, 1, 0, 0, 0);
      wait_frames(2);
      chk("R3 ratio 32", last_ratio, 32);
      chk("R2 bclk period div2", last_bper, 2);

      // R2 R3 R6 divide 4, frame 64, falling edge
      drive(1, 1, 1, 1, 1);
      wait_frames(2);
      chk("R3 ratio 64", last_ratio, 64);
      chk("R2 bclk period div4", last_bper, 4);

      // R3 R9 frame 128 with random ticks
      tick_mode = 2;
      drive(1, 1, 0, 2, 0);
      wait_frames(2);
      chk("R3 ratio 128", last_ratio, 128);

      // R9 sparse ticks, divide 4: one toggle per 2 ticks of 3 cycles
      tick_mode = 1;
      drive(1, 1, 1, 0, 1);
      wait_frames(2);
      chk("R9 bclk period sparse", last_bper, 12);
      chk("R3 ratio 32 sparse", last_ratio, 32);

      // R4 illegal frame select
      tick_mode = 0;
      drive(1, 1, 0, 3, 0);
      repeat (400) @(negedge clk);
      chk("R4 fclk never high", fclk_seen_high, 0);
      chk("R4 bclk still running", bclk_rises > 100, 1);

      // R7 settings from audio block when override is clear
      aud_bdiv_sel = 1'b0; aud_fdiv_sel = 2'd1; aud_fall_pol = 1'b1;
      drive(1, 0, 0, 0, 1);
      wait_frames(2);
      chk("R7 ratio from aud", last_ratio, 64);
      chk("R7 bclk period from aud", last_bper, 2);

      // R5 disable mid-frame, then fresh start
      repeat (37) @(negedge clk);
      drive(0, 1, 0, 0, 0);
      @(negedge clk);
      chk("R5 off bclk", bclk_o, 0); chk("R5 off fclk", fclk_o, 0);
      repeat (5) @(negedge clk);
      drive(1, 1, 0, 0, 0);
      wait_frames(1);
      chk("R5 first half frame", last_ratio, 16);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule